// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit sits beside the core of a small 8-bit processor and decides, at each instruction boundary, whether an interrupt is taken and where execution goes. It watches five request pins. One is non-maskable. Three are vectored and maskable. The fifth is a non-vectored external request that is answered with an acknowledge pulse instead of an address. The unit holds the global enable flag, three per-source mask bits, an edge latch for the top maskable source, an edge latch for the non-maskable source, and a serial-output bit.

Software changes the configuration with a one-byte configuration write. Separate enable bits inside that byte gate the mask load and the serial-output update. Software reads state back through a status byte that is always present on an output. The core tells the unit where an instruction boundary falls. When the unit accepts a request, it gives a one-cycle accept strobe and either a 16-bit vector or an external acknowledge. The core performs the call itself.

Top module: `irq_prio_unit`

## Requirements
- R1: After synchronous reset, the enable flag is 0, all three masks are 1, both edge latches are clear, serOut is 0 and accept is 0. With serIn low, statusByte reads 07H.
- R2: When several eligible requests are present, exactly one is taken. The order from highest to lowest is nmiPin, edgePin, lvlAPin, lvlBPin, extPin.
- R3: The vectors are 0024H for nmiPin, 003CH for edgePin, 0034H for lvlAPin and 002CH for lvlBPin. Each equals four times twice its restart number (9, 15, 13, 11 half-steps).
- R4: Taking extPin raises accept, isExt and extAck together, with vector 0000H. Vectored takes have isExt and extAck at 0.
- R5: nmiPin is taken regardless of the enable flag and the masks.
- R6: edgePin, lvlAPin and lvlBPin need the enable flag set and their mask clear. The masks are cfg bits 2, 1 and 0, and 1 means masked. extPin needs only the enable flag. lvlAPin, lvlBPin and extPin act on their level at the boundary.
- R7: A rising edge on edgePin sets a latch. The latch stays set after the pin falls. It is cleared by taking that source, or by a configuration write with bit 4 set.
- R8: nmiPin is taken only after a rising edge, and only while the pin is still high. Holding the pin high after a take gives no second take. A pulse that falls before the boundary is lost.
- R9: A take happens only when boundary is high. accept follows one clock after that boundary cycle. The take clears the enable flag. ieSet sets the flag and ieClr clears it. A clear wins over a set in the same cycle.
- R10: A configuration write loads cfgData[2:0] into the masks only when bit 3 is 1. It copies bit 7 to serOut only when bit 6 is 1. Bit 5 has no effect.
- R11: statusByte is {serIn, edge latch, lvlAPin, lvlBPin, enable flag, mask7.5, mask6.5, mask5.5} from bit 7 down to bit 0. For example, with the flag set, masks 011 and the edge latch set, it reads 4BH.
- R12: accept is a single-cycle pulse for each take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boundary | input | 1 | Instruction boundary strobe from the core |
| nmiPin | input | 1 | Non-maskable request, needs an edge and a held level |
| edgePin | input | 1 | Highest maskable request, edge-latched |
| lvlAPin | input | 1 | Middle maskable request, level |
| lvlBPin | input | 1 | Lowest vectored maskable request, level |
| extPin | input | 1 | Non-vectored external request, level |
| ieSet | input | 1 | Enable-flag set command |
| ieClr | input | 1 | Enable-flag clear command |
| cfgWr | input | 1 | Configuration byte write strobe |
| cfgData | input | 8 | Configuration byte |
| statusByte | output | 8 | Status read byte |
| serIn | input | 1 | Serial input pin, reported in the status byte |
| serOut | output | 1 | Serial output latch |
| accept | output | 1 | One-cycle interrupt take strobe |
| vector | output | 16 | Target address for vectored takes |
| isExt | output | 1 | The take is the non-vectored source |
| extAck | output | 1 | Acknowledge pulse for the external request |

## Verification
The bench sweeps every combination of the five pins, the enable flag and the three masks. A wrong priority order or a mask bit wired to the wrong source would show up as a wrong vector there. Dedicated sequences cover the corner cases:
- **Edge latch after the pin falls.** A level-only implementation would lose that request.
- **Clear by configuration bit 4.** An implementation that ignores the bit would take a stale request.
- **Held non-maskable level after a take.** A level-triggered implementation would take the request again and again.
- **Non-maskable pulse gone before the boundary.** An edge-only implementation would take a request that has already disappeared.
- **Gated configuration bits.** Writes with bit 3 or bit 6 clear must change nothing, so a design that ignores the gates shows altered masks or serOut.
- **Enable flag after a take.** A take must leave the enable flag cleared, so a later boundary brings no take until ieSet.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC  = 5;
  localparam int SRC_W = $clog2(NSRC);
  localparam int VEC_W = 16;
  localparam int EXT_IDX = NSRC - 1;

  // priority order: index 0 is the highest
  typedef struct packed {
    logic clrIe;
    logic clrEdge;
    logic clrNmi;
  } dpStrobe_t;

  // vector = restart number * 8 = half-step count * 4
  function automatic logic [VEC_W-1:0] vecOf(input logic [SRC_W-1:0] idx);
    logic [7:0] halfSteps;
    case (idx)
      3'd0:    halfSteps = 8'd9;
      3'd1:    halfSteps = 8'd15;
      3'd2:    halfSteps = 8'd13;
      3'd3:    halfSteps = 8'd11;
      default: halfSteps = 8'd0;
    endcase
    return VEC_W'({halfSteps, 2'b00});
  endfunction
endpackage

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            nmiPin,
  input  logic            edgePin,
  input  logic            lvlAPin,
  input  logic            lvlBPin,
  input  logic            extPin,
  input  logic            ieSet,
  input  logic            ieClr,
  input  logic            cfgWr,
  input  logic [7:0]      cfgData,
  input  logic            serIn,
  input  dpStrobe_t       strb,
  output logic [NSRC-1:0] rawPend,
  output logic [2:0]      maskBits,
  output logic            ieFlag,
  output logic [7:0]      statusByte,
  output logic            serOut
);
  logic edgeLatch, edgePrev, nmiLatch, nmiPrev;
  logic edgeRise, nmiRise, cfgEdgeClr, cfgMaskLd, cfgSerLd;
  wire  unusedCfgBit = cfgData[5];

  assign edgeRise   = edgePin & ~edgePrev;
  assign nmiRise    = nmiPin & ~nmiPrev;
  assign cfgEdgeClr = cfgWr & cfgData[4];
  assign cfgMaskLd  = cfgWr & cfgData[3];
  assign cfgSerLd   = cfgWr & cfgData[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeLatch <= 1'b0;
      edgePrev  <= 1'b0;
      nmiLatch  <= 1'b0;
      nmiPrev   <= 1'b0;
      ieFlag    <= 1'b0;
      maskBits  <= 3'b111;
      serOut    <= 1'b0;
    end else begin
      edgePrev  <= edgePin;
      nmiPrev   <= nmiPin;
      edgeLatch <= edgeRise | (edgeLatch & ~(strb.clrEdge | cfgEdgeClr));
      nmiLatch  <= nmiPin & (nmiRise | (nmiLatch & ~strb.clrNmi));
      if (strb.clrIe || ieClr) ieFlag <= 1'b0;
      else if (ieSet)          ieFlag <= 1'b1;
      if (cfgMaskLd) maskBits <= cfgData[2:0];
      if (cfgSerLd)  serOut   <= cfgData[7];
    end
  end

  assign rawPend    = {extPin, lvlBPin, lvlAPin, edgeLatch, nmiLatch & nmiPin};
  assign statusByte = {serIn, edgeLatch, lvlAPin, lvlBPin, ieFlag, maskBits};

  // R10: masks move only on a gated configuration write
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfgMaskLd)) |-> $stable(maskBits));
  // R10: serial output moves only on a gated configuration write
  a_r10_serout_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfgSerLd)) |-> $stable(serOut));
  // R7: the edge latch holds until it is taken or cleared by configuration
  a_r7_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(edgeLatch) && !$past(strb.clrEdge) && !$past(cfgEdgeClr))
      |-> edgeLatch);
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic [NSRC-1:0]  rawPend,
  input  logic [2:0]       maskBits,
  input  logic             ieFlag,
  output dpStrobe_t        strb,
  output logic             accept,
  output logic [VEC_W-1:0] vector,
  output logic             isExt,
  output logic             extAck
);
  logic [NSRC-1:0]  elig;
  logic [SRC_W-1:0] grantIdx;
  logic             found, take;

  // index 0 ignores enable and masks; the last index needs only the enable
  assign elig[0]       = rawPend[0];
  assign elig[EXT_IDX] = rawPend[EXT_IDX] & ieFlag;
  generate
    for (genvar g = 1; g < EXT_IDX; g++) begin : g_masked
      assign elig[g] = rawPend[g] & ieFlag & ~maskBits[3-g];
    end
  endgenerate

  always_comb begin
    grantIdx = '0;
    found    = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grantIdx = SRC_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign take         = boundary & found;
  assign strb.clrIe   = take;
  assign strb.clrEdge = take & (grantIdx == SRC_W'(1));
  assign strb.clrNmi  = take & (grantIdx == SRC_W'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      accept <= 1'b0;
      vector <= '0;
      isExt  <= 1'b0;
      extAck <= 1'b0;
    end else begin
      accept <= take;
      vector <= take ? vecOf(grantIdx) : '0;
      isExt  <= take & (grantIdx == SRC_W'(EXT_IDX));
      extAck <= take & (grantIdx == SRC_W'(EXT_IDX));
    end
  end

  // R9: a take follows a boundary cycle
  a_r9_accept_after_boundary: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(boundary));
  // R9: the enable flag is already cleared when accept shows
  a_r9_ie_cleared: assert property (@(posedge clk) disable iff (rst)
    accept |-> !ieFlag);
  // R12: accept never lasts two cycles
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);
  // R4: the acknowledge comes only with a non-vectored take
  a_r4_ext_ack: assert property (@(posedge clk) disable iff (rst)
    extAck |-> (accept && isExt && vector == '0));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        boundary,
  input  logic        nmiPin,
  input  logic        edgePin,
  input  logic        lvlAPin,
  input  logic        lvlBPin,
  input  logic        extPin,
  input  logic        ieSet,
  input  logic        ieClr,
  input  logic        cfgWr,
  input  logic [7:0]  cfgData,
  output logic [7:0]  statusByte,
  input  logic        serIn,
  output logic        serOut,
  output logic        accept,
  output logic [15:0] vector,
  output logic        isExt,
  output logic        extAck
);
  dpStrobe_t       strb;
  logic [NSRC-1:0] rawPend;
  logic [2:0]      maskBits;
  logic            ieFlag;

  irq_prio_dp u_dp (
    .clk(clk), .rst(rst), .nmiPin(nmiPin), .edgePin(edgePin),
    .lvlAPin(lvlAPin), .lvlBPin(lvlBPin), .extPin(extPin),
    .ieSet(ieSet), .ieClr(ieClr), .cfgWr(cfgWr), .cfgData(cfgData),
    .serIn(serIn), .strb(strb), .rawPend(rawPend), .maskBits(maskBits),
    .ieFlag(ieFlag), .statusByte(statusByte), .serOut(serOut)
  );

  irq_prio_ctl u_ctl (
    .clk(clk), .rst(rst), .boundary(boundary), .rawPend(rawPend),
    .maskBits(maskBits), .ieFlag(ieFlag), .strb(strb), .accept(accept),
    .vector(vector), .isExt(isExt), .extAck(extAck)
  );

  // R5: a take at the non-maskable vector needs the pin high at the boundary
  a_r5_nmi_level: assert property (@(posedge clk) disable iff (rst)
    (accept && vector == 16'h0024) |-> $past(nmiPin));
endmodule

// File: tb/irq_prio_unit_bench.sv
module irq_prio_unit_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic boundary = 0, nmiPin = 0, edgePin = 0, lvlAPin = 0, lvlBPin = 0, extPin = 0;
  logic ieSet = 0, ieClr = 0, cfgWr = 0, serIn = 0;
  logic [7:0] cfgData = '0;
  logic [7:0] statusByte;
  logic serOut, accept, isExt, extAck;
  logic [15:0] vector;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_prio_unit u_irq_prio_unit (
    .clk(clk), .rst(rst), .boundary(boundary), .nmiPin(nmiPin), .edgePin(edgePin),
    .lvlAPin(lvlAPin), .lvlBPin(lvlBPin), .extPin(extPin), .ieSet(ieSet),
    .ieClr(ieClr), .cfgWr(cfgWr), .cfgData(cfgData), .statusByte(statusByte),
    .serIn(serIn), .serOut(serOut), .accept(accept), .vector(vector),
    .isExt(isExt), .extAck(extAck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] d);
    cfgWr = 1; cfgData = d; step(); cfgWr = 0; cfgData = '0;
  endtask

  task automatic pulseIe(input bit en);
    ieSet = en; ieClr = !en; step(); ieSet = 0; ieClr = 0;
  endtask

  // boundary cycle; accept is registered and visible at the next negedge
  task automatic take(input string req, input bit expAcc, input logic [15:0] expVec,
                      input bit expExt);
    boundary = 1; step(); boundary = 0;
    chk(req, accept, expAcc);
    chk(req, vector, expVec);
    chk(req, isExt, expExt);
    chk(req, extAck, expExt);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] ev;
    bit acc, ex;
    repeat (2) step();
    rst = 0;
    step();
    // R1 / R11: reset values
    chk("R1 status", statusByte, 8'h07);
    chk("R1 serOut", serOut, 0);
    chk("R1 accept", accept, 0);

    // R10: gated configuration writes
    cfg(8'h0A);  chk("R10 mask load 0A", statusByte[2:0], 3'b010);
    cfg(8'h07);  chk("R10 mask gate off", statusByte[2:0], 3'b010);
    cfg(8'hC0);  chk("R10 serOut set", serOut, 1);
    cfg(8'h80);  chk("R10 serOut gate off", serOut, 1);
    cfg(8'h2F);  chk("R10 bit5 no effect mask", statusByte[2:0], 3'b111);
    chk("R10 bit5 no effect serOut", serOut, 1);
    cfg(8'h54);  chk("R10 54H serOut low", serOut, 0);
    chk("R10 54H masks kept", statusByte[2:0], 3'b111);

    // R11: example status 4BH
    cfg(8'h0B); pulseIe(1);
    edgePin = 1; step(); edgePin = 0; step();
    chk("R11 status 4B", statusByte, 8'h4B);
    serIn = 1; step(); chk("R11 serIn bit7", statusByte[7], 1); serIn = 0;

    // R7: latch survives pin fall, cleared by take, and by cfg bit4
    cfg(8'h08); repeat (3) step();
    chk("R7 latch held", statusByte[6], 1);
    take("R7 take edge", 1, 16'h003C, 0);
    chk("R7 cleared by take", statusByte[6], 0);
    edgePin = 1; step(); edgePin = 0; step();
    chk("R7 relatched", statusByte[6], 1);
    cfg(8'h10);
    chk("R7 cleared by cfg", statusByte[6], 0);
    chk("R7 cfg kept masks", statusByte[2:0], 3'b000);

    // R8 / R5: non-maskable edge plus level, enable flag is off here
    chk("R5 ie off", statusByte[3], 0);
    cfg(8'h0F);
    nmiPin = 1; step();
    take("R8 nmi taken", 1, 16'h0024, 0);
    step();
    take("R8 held level no retake", 0, 16'h0000, 0);
    nmiPin = 0; step(); nmiPin = 1; step();
    take("R8 new edge taken", 1, 16'h0024, 0);
    nmiPin = 0; step(); nmiPin = 1; step(); nmiPin = 0; step();
    take("R8 short pulse lost", 0, 16'h0000, 0);

    // R9 / R12: boundary gating, enable clearing, set/clear commands
    cfg(8'h08); pulseIe(1); lvlBPin = 1;
    repeat (3) begin step(); chk("R9 no boundary no take", accept, 0); end
    take("R9 take lvlB", 1, 16'h002C, 0);
    chk("R9 ie cleared", statusByte[3], 0);
    step(); chk("R12 single pulse", accept, 0);
    take("R9 no take with ie off", 0, 16'h0000, 0);
    pulseIe(1);
    take("R9 retake after set", 1, 16'h002C, 0);
    ieSet = 1; ieClr = 1; step(); ieSet = 0; ieClr = 0;
    chk("R9 clear wins", statusByte[3], 0);
    pulseIe(1); pulseIe(0);
    take("R9 ieClr blocks", 0, 16'h0000, 0);
    lvlBPin = 0; step();

    // R2 R3 R4 R5 R6: sweep pins x enable x masks
    for (int p = 0; p < 32; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int m = 0; m < 8; m++) begin
          cfgWr = 1; cfgData = 8'h18 | 8'(m); ieSet = e[0]; ieClr = !e[0]; step();
          cfgWr = 0; cfgData = '0; ieSet = 0; ieClr = 0;
          nmiPin = p[0]; edgePin = p[1]; lvlAPin = p[2]; lvlBPin = p[3]; extPin = p[4];
          step();
          acc = 1; ex = 0;
          if (p[0])                     ev = 16'h0024;
          else if (e[0] && p[1] && !m[2]) ev = 16'h003C;
          else if (e[0] && p[2] && !m[1]) ev = 16'h0034;
          else if (e[0] && p[3] && !m[0]) ev = 16'h002C;
          else if (e[0] && p[4]) begin ev = 16'h0000; ex = 1; end
          else begin ev = 16'h0000; acc = 0; end
          take("R2 R3 R4 R5 R6 sweep", acc, ev, ex);
          chk("R9 sweep ie after", statusByte[3], e[0] && !acc);
          {nmiPin, edgePin, lvlAPin, lvlBPin, extPin} = '0;
          step();
          chk("R12 sweep pulse", accept, 0);
        end
      end
    end
    report();
  end
endmodule